// File: doc/BRIEF.md
# Interrupt Route Map Decoder

This block keeps a routing table with one entry for each external interrupt line; the entry names the CPU that the line is steered to. A producer writes the table one 32-bit word at a time. Each word covers a group of four consecutive lines and carries one byte per line. A byte-lane strobe selects which lines in the group are written. Each enabled byte is decoded into a CPU number under the decode mode that applies when the word is accepted. In mask mode the byte is a CPU mask, and the target is its lowest set bit, clamped to CPU 0 when that bit is out of range. In direct mode the byte itself is the CPU number.

Whenever a line's stored target actually changes, the block emits a change event on an output stream. The event carries the line number, the old CPU and the new CPU, so that downstream logic can move pending interrupts to the new target. Both sides of the block use valid/ready handshakes. A write is accepted only while no events from the previous write are waiting. Once a word is accepted, its events come out one per completed handshake, in ascending line order. While `chg_ready` is low, the event on offer and its fields are held unchanged. `wr_ready` stays low until the last event has been taken, so a slow event consumer throttles the writer.

Top module: `irq_route_map`

## Requirements
- R1: Byte k of `wr_data` (bits 8k+7..8k) belongs to interrupt line 4·`wr_index`+k, so the lowest byte maps to the lowest line of the group, and every event reports that line number on `chg_irq`.
- R2: With `cpu_encode` low at acceptance, the new target is the bit position of the lowest set bit of the byte (bit 0 gives CPU 0, up to bit 3 giving CPU 3).
- R3: In mask mode, a byte equal to zero, or one whose lowest set bit is position 4 or higher, gives CPU 0.
- R4: With `cpu_encode` high at acceptance, the new target is the byte value unchanged (0x00 to 0xFF).
- R5: An enabled line whose decoded target equals its stored target keeps its entry and produces no event; every event has `chg_old` different from `chg_new`.
- R6: A line whose `wr_strb` bit is low keeps its stored target and produces no event.
- R7: After reset every line targets CPU 0, `wr_ready` is high and `chg_valid` is low.
- R8: The events of one write are offered in ascending line order, one per `chg_valid`/`chg_ready` handshake. While `chg_ready` is low, `chg_irq`, `chg_old` and `chg_new` stay stable.
- R9: `wr_ready` is low while any event of the previous write is still waiting, and high otherwise. A write offered while `wr_ready` is low is not taken.
- R10: The decode mode is sampled separately for each accepted write, so switching `cpu_encode` between writes changes only how later words are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_encode | input | 1 | Decode mode: 0 = lowest-bit mask, 1 = direct CPU number |
| wr_valid | input | 1 | Table write offered |
| wr_ready | output | 1 | Table write can be taken |
| wr_index | input | 6 | Group index (group of four lines) |
| wr_data | input | 32 | One routing byte per line of the group |
| wr_strb | input | 4 | Byte-lane enables |
| chg_valid | output | 1 | Change event offered |
| chg_ready | input | 1 | Consumer takes the change event |
| chg_irq | output | 8 | Line whose target changed |
| chg_old | output | 8 | Previous target CPU |
| chg_new | output | 8 | New target CPU |

## Verification
The mask decoder is driven with single-bit masks that map to each of the four in-range CPUs, with multi-bit masks whose lowest bit has to win, with a zero byte, and with masks whose lowest bit is 4 or higher. These patterns separate a correct lowest-bit scan from a highest-bit scan and from a missing clamp. Direct-mode words carry values above the CPU count, which shows that no scan is applied in that mode. Rewriting stored values, sparse strobes and the first and last groups show suppression of unchanged lines, lane gating, and byte-to-line ordering at the table edges. The event stream is stalled while a second write is offered, and a reset is applied in the middle of a run; together these show that events are held, that writes are refused while events wait, and that the table returns to CPU 0.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int CPU_W = 8;

  typedef logic [CPU_W-1:0] cpu_id_t;

  typedef enum logic {
    DEC_MASK   = 1'b0,
    DEC_DIRECT = 1'b1
  } dec_mode_e;

  typedef struct packed {
    cpu_id_t old_cpu;
    cpu_id_t new_cpu;
  } cpu_pair_t;

endpackage

// File: rtl/route_lane_decode.sv
module route_lane_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  cpu_id_t   raw,
  input  dec_mode_e mode,
  output cpu_id_t   cpu
);

  localparam int      IW  = $clog2(CPU_W);
  localparam cpu_id_t LIM = CPU_W'(NUM_CPU);

  logic [IW-1:0] pos;
  logic          hit;
  cpu_id_t       pos_ext;

  // scan from the top so the lowest set bit is the last one written
  always_comb begin
    pos = '0;
    hit = 1'b0;
    for (int i = CPU_W - 1; i >= 0; i--) begin
      if (raw[i]) begin
        pos = IW'(i);
        hit = 1'b1;
      end
    end
  end

  assign pos_ext = cpu_id_t'(pos);

  always_comb begin
    if (mode == DEC_DIRECT)
      cpu = raw;
    else if (hit && (pos_ext < LIM))
      cpu = pos_ext;
    else
      cpu = '0;
  end

endmodule

// File: rtl/route_table.sv
module route_table
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 256,
  parameter int LANES   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(NUM_IRQ)-$clog2(LANES)-1:0] grp,
  output cpu_id_t [LANES-1:0]          rd_cpu,
  input  logic [LANES-1:0]             we,
  input  cpu_id_t [LANES-1:0]          wd_cpu
);

  localparam int LB = $clog2(LANES);

  cpu_id_t mem [NUM_IRQ];

  for (genvar l = 0; l < LANES; l++) begin : g_port
    assign rd_cpu[l] = mem[{grp, LB'(l)}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQ; i++) mem[i] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (we[l]) mem[{grp, LB'(l)}] <= wd_cpu[l];
      end
    end
  end

endmodule

// File: rtl/chg_serializer.sv
module chg_serializer
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 256,
  parameter int LANES   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [LANES-1:0]              load_mask,
  input  logic [$clog2(NUM_IRQ)-$clog2(LANES)-1:0] load_grp,
  input  cpu_pair_t [LANES-1:0]         load_pair,
  output logic                          busy,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [$clog2(NUM_IRQ)-1:0]    out_irq,
  output cpu_id_t                       out_old,
  output cpu_id_t                       out_new
);

  localparam int LB    = $clog2(LANES);
  localparam int GRP_W = $clog2(NUM_IRQ) - LB;

  logic [LANES-1:0]      pend;
  logic [GRP_W-1:0]      grp_q;
  cpu_pair_t [LANES-1:0] pair_q;
  logic [LB-1:0]         sel;

  always_comb begin
    sel = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (pend[l]) sel = LB'(l);
    end
  end

  assign busy      = |pend;
  assign out_valid = busy;
  assign out_irq   = {grp_q, sel};
  assign out_old   = pair_q[sel].old_cpu;
  assign out_new   = pair_q[sel].new_cpu;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      grp_q  <= '0;
      pair_q <= '0;
    end else if (load) begin
      pend   <= load_mask;
      grp_q  <= load_grp;
      pair_q <= load_pair;
    end else if (out_valid && out_ready) begin
      pend[sel] <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_route_map.sv
module irq_route_map
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 256,
  parameter int NUM_CPU = 4,
  parameter int LANES   = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cpu_encode,
  input  logic                                   wr_valid,
  output logic                                   wr_ready,
  input  logic [$clog2(NUM_IRQ)-$clog2(LANES)-1:0] wr_index,
  input  logic [LANES*CPU_W-1:0]                 wr_data,
  input  logic [LANES-1:0]                       wr_strb,
  output logic                                   chg_valid,
  input  logic                                   chg_ready,
  output logic [$clog2(NUM_IRQ)-1:0]             chg_irq,
  output logic [CPU_W-1:0]                       chg_old,
  output logic [CPU_W-1:0]                       chg_new
);

  dec_mode_e             mode;
  logic                  accept;
  logic                  busy;
  cpu_id_t [LANES-1:0]   cur_cpu;
  cpu_id_t [LANES-1:0]   dec_cpu;
  logic [LANES-1:0]      differ;
  logic [LANES-1:0]      we;
  cpu_pair_t [LANES-1:0] pair;

  assign mode     = cpu_encode ? DEC_DIRECT : DEC_MASK;
  assign wr_ready = !busy;
  assign accept   = wr_valid && wr_ready;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    route_lane_decode #(.NUM_CPU(NUM_CPU)) u_dec (
      .raw  (wr_data[l*CPU_W +: CPU_W]),
      .mode (mode),
      .cpu  (dec_cpu[l])
    );
    assign differ[l]       = wr_strb[l] && (dec_cpu[l] != cur_cpu[l]);
    assign pair[l].old_cpu = cur_cpu[l];
    assign pair[l].new_cpu = dec_cpu[l];
  end

  assign we = accept ? differ : '0;

  route_table #(.NUM_IRQ(NUM_IRQ), .LANES(LANES)) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .grp    (wr_index),
    .rd_cpu (cur_cpu),
    .we     (we),
    .wd_cpu (dec_cpu)
  );

  chg_serializer #(.NUM_IRQ(NUM_IRQ), .LANES(LANES)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_mask (differ),
    .load_grp  (wr_index),
    .load_pair (pair),
    .busy      (busy),
    .out_valid (chg_valid),
    .out_ready (chg_ready),
    .out_irq   (chg_irq),
    .out_old   (chg_old),
    .out_new   (chg_new)
  );

endmodule

// File: rtl/irq_route_map_chk.sv
module irq_route_map_chk
  import irq_route_pkg::*;
#(
  parameter int NUM_IRQ = 256,
  parameter int NUM_CPU = 4,
  parameter int LANES   = 4
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   cpu_encode,
  input logic                                   wr_valid,
  input logic                                   wr_ready,
  input logic [$clog2(NUM_IRQ)-$clog2(LANES)-1:0] wr_index,
  input logic                                   chg_valid,
  input logic                                   chg_ready,
  input logic [$clog2(NUM_IRQ)-1:0]             chg_irq,
  input logic [CPU_W-1:0]                       chg_old,
  input logic [CPU_W-1:0]                       chg_new
);

  localparam int      IRQ_W = $clog2(NUM_IRQ);
  localparam int      LB    = $clog2(LANES);
  localparam cpu_id_t LIM   = CPU_W'(NUM_CPU);

  logic [IRQ_W-LB-1:0] grp_q;
  logic                enc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q <= '0;
      enc_q <= 1'b0;
    end else if (wr_valid && wr_ready) begin
      grp_q <= wr_index;
      enc_q <= cpu_encode;
    end
  end

  AST_EVENT_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> (chg_irq[IRQ_W-1:LB] == grp_q)); // R1

  AST_MASK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_valid && !enc_q) |-> (chg_new < LIM)); // R3

  AST_EVENT_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> (chg_old != chg_new)); // R5

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_valid && !chg_ready) |=> (chg_valid && $stable(chg_irq)
                                   && $stable(chg_old) && $stable(chg_new))); // R8

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_valid && chg_ready) |=> (!chg_valid || (chg_irq > $past(chg_irq)))); // R8

  AST_NO_TAKE_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid |-> !wr_ready); // R9

endmodule

bind irq_route_map irq_route_map_chk #(
  .NUM_IRQ (NUM_IRQ),
  .NUM_CPU (NUM_CPU),
  .LANES   (LANES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_encode (cpu_encode),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_index   (wr_index),
  .chg_valid  (chg_valid),
  .chg_ready  (chg_ready),
  .chg_irq    (chg_irq),
  .chg_old    (chg_old),
  .chg_new    (chg_new)
);

// File: tb/irq_route_map_tb.sv
`timescale 1ns/1ps
module irq_route_map_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_encode = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [5:0]  wr_index = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_strb = '0;
  logic        chg_valid;
  logic        chg_ready = 1'b0;
  logic [7:0]  chg_irq;
  logic [7:0]  chg_old;
  logic [7:0]  chg_new;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_tbl [256];

  always #4 clk = ~clk;

  irq_route_map u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_encode(cpu_encode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_index(wr_index),
    .wr_data(wr_data), .wr_strb(wr_strb),
    .chg_valid(chg_valid), .chg_ready(chg_ready),
    .chg_irq(chg_irq), .chg_old(chg_old), .chg_new(chg_new)
  );

  // {mode(1), group(6), strobe(4), data(32)}
  localparam int NV = 10;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 6'd0,  4'hF, 32'h08040201},
    {1'b0, 6'd0,  4'hF, 32'h80100006},
    {1'b1, 6'd5,  4'hF, 32'hFF03C702},
    {1'b1, 6'd5,  4'h5, 32'h11223344},
    {1'b1, 6'd5,  4'hF, 32'hFF22C744},
    {1'b0, 6'd63, 4'hF, 32'h010C30F8},
    {1'b0, 6'd5,  4'hF, 32'h40020100},
    {1'b0, 6'd5,  4'h0, 32'hFFFFFFFF},
    {1'b1, 6'd63, 4'h8, 32'h07000000},
    {1'b0, 6'd31, 4'h2, 32'h00000400}
  };

  function automatic logic [7:0] ref_mask(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (b[i]) return (i < 4) ? 8'(i) : 8'd0;
    end
    return 8'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_write(input logic enc, input logic [5:0] idx,
                           input logic [3:0] strb, input logic [31:0] data);
    int n = 0;
    int e_irq [4];
    int e_old [4];
    int e_new [4];
    string req = enc ? "R4" : "R2";
    for (int l = 0; l < 4; l++) begin
      int irq = idx * 4 + l;
      logic [7:0] b = data[l*8 +: 8];
      logic [7:0] nv = enc ? b : ref_mask(b);
      if (strb[l] && nv != ref_tbl[irq]) begin
        e_irq[n] = irq; e_old[n] = ref_tbl[irq]; e_new[n] = nv;
        ref_tbl[irq] = nv;
        n++;
      end
    end
    @(negedge clk);
    chk(wr_ready == 1'b1, "R9", "wr_ready idle", wr_ready, 1);
    cpu_encode = enc; wr_index = idx; wr_strb = strb; wr_data = data;
    wr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk(chg_valid == 1'b1, "R8", "event present", chg_valid, 1);
      chk(wr_ready == 1'b0, "R9", "wr_ready while pending", wr_ready, 0);
      chk(chg_irq == 8'(e_irq[k]), "R1", "event line", chg_irq, e_irq[k]);
      chk(chg_old == 8'(e_old[k]), "R5", "old cpu", chg_old, e_old[k]);
      chk(chg_new == 8'(e_new[k]), req, "new cpu", chg_new, e_new[k]);
      chg_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chg_ready = 1'b0;
    end
    chk(chg_valid == 1'b0, "R5/R6", "no further event", chg_valid, 0);
    chk(wr_ready == 1'b1, "R9", "wr_ready after drain", wr_ready, 1);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_tbl[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state at the ports
    chk(wr_ready == 1'b1, "R7", "wr_ready after reset", wr_ready, 1);
    chk(chg_valid == 1'b0, "R7", "chg_valid after reset", chg_valid, 0);

    // vector table: R1 R2 R3 R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      run_write(VEC[v][42], VEC[v][41:36], VEC[v][35:32], VEC[v][31:0]);
    end

    // R8/R9: stall the event stream and offer a second write meanwhile
    @(negedge clk);
    cpu_encode = 1'b1; wr_index = 6'd10; wr_strb = 4'hF;
    wr_data = 32'h05000009; wr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ref_tbl[40] = 8'd9; ref_tbl[43] = 8'd5;
    wr_index = 6'd10; wr_strb = 4'h2; wr_data = 32'h00000700;
    for (int c = 0; c < 3; c++) begin
      chk(chg_valid == 1'b1, "R8", "held valid", chg_valid, 1);
      chk(chg_irq == 8'd40, "R8", "held line", chg_irq, 40);
      chk(chg_new == 8'd9, "R8", "held new cpu", chg_new, 9);
      chk(wr_ready == 1'b0, "R9", "write refused", wr_ready, 0);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    chg_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(chg_irq == 8'd43, "R8", "second event line", chg_irq, 43);
    chk(chg_new == 8'd5, "R8", "second event cpu", chg_new, 5);
    @(posedge clk);
    @(negedge clk);
    chg_ready = 1'b0;
    chk(chg_valid == 1'b0, "R8", "drained", chg_valid, 0);
    // refused write must not have landed: line 41 still 0
    run_write(1'b1, 6'd10, 4'h2, 32'h00000700);

    // R7: reset in mid-run returns every line to CPU 0
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) ref_tbl[i] = 8'd0;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R7", "wr_ready after second reset", wr_ready, 1);
    run_write(1'b1, 6'd63, 4'hF, 32'h01010101);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule